// File: doc/BRIEF.md
# Multiprocessor Wake-Up Sequencer

This block takes the place of boot firmware in waking the secondary processors of a shared-memory system. A one-cycle start pulse launches a fixed three-message sequence, written through the command-register write port of an interprocessor interrupt unit. The first message is an initialise broadcast to every processor except the sender. Two start-up broadcasts follow, and each carries an entry vector. Once a command has been written, the sequencer watches the unit's delivery-busy flag and holds until delivery completes. It then spends a timed gap of clock cycles before it issues the next command.

The gaps are 10 ms after the initialise message and 200 µs after each start-up message. They are derived at elaboration from the clock frequency, with rounding up. After the last gap the block samples the shared processor count and puts it on its output. The count starts at 1, which stands for the boot processor alone, and is incremented by every processor that wakes. A delivery that stays busy for too long aborts the sequence and raises an error flag.

States: `ST_IDLE`, `ST_SEND_INIT`, `ST_POLL_INIT`, `ST_WAIT_INIT`, `ST_SEND_SIPI1`, `ST_POLL_SIPI1`, `ST_WAIT_SIPI1`, `ST_SEND_SIPI2`, `ST_POLL_SIPI2`, `ST_WAIT_SIPI2`, `ST_SAMPLE`.

Transitions:
- `ST_IDLE` moves to `ST_SEND_INIT` on start.
- Each `SEND` state moves to its `POLL` state.
- Each `POLL` state moves to its `WAIT` state when busy is low, and back to `ST_IDLE` on a timeout.
- `ST_WAIT_INIT` moves to `ST_SEND_SIPI1` when its gap ends.
- `ST_WAIT_SIPI1` moves to `ST_SEND_SIPI2` when its gap ends.
- `ST_WAIT_SIPI2` moves to `ST_SAMPLE` when its gap ends.
- `ST_SAMPLE` moves to `ST_IDLE`.

Top module: `mp_wake_seq`

## Requirements
- R1: An accepted start produces exactly three command writes, in order: initialise, start-up, start-up. Each write lasts one cycle, and the first comes in the cycle after start is sampled.
- R2: The initialise write carries the word 0x000C4500. This word encodes all-except-self shorthand (bits 19:18 = 11), level assert (bit 14), initialise delivery mode (bits 10:8 = 101) and vector 0.
- R3: Each start-up write carries 0x000C4600 ORed with the 8-bit vector in bits 7:0. The vector is captured from `sipi_vec_i` in the cycle start is accepted.
- R4: Busy is first sampled in the cycle after each write. While `busy_i` reads 1 the block makes no write and its gap does not begin. The gap starts in the first cycle in which busy reads 0.
- R5: The gap after the initialise write lasts ceil(INIT_US·CLK_HZ/1e6) cycles, which is 11932 at the defaults. Each gap after a start-up write lasts ceil(SIPI_US·CLK_HZ/1e6) cycles, which is 239. The next write or the sample follows directly after the gap.
- R6: In the cycle after the final gap, `done_o` is high for exactly one cycle, and in that cycle `count_o` equals `cpu_count_i`.
- R7: `count_o` is 0 after reset. It holds the sampled value until the next accepted start, which clears it to 0.
- R8: A start pulse has no effect in any state other than idle, including the cycle in which done is high.
- R9: If busy reads 1 on BUSY_TMO consecutive poll cycles, the sequence aborts to idle with no further writes and `error_o` goes high. The flag stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a sequence when idle |
| busy_i | input | 1 | Delivery-busy flag of the interrupt unit |
| cpu_count_i | input | CNT_W | Shared processor count |
| sipi_vec_i | input | 8 | Start-up entry vector (entry address = vector·4096) |
| cmd_we_o | output | 1 | Command-register write strobe |
| cmd_data_o | output | 32 | Command word |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Busy timeout occurred |
| count_o | output | CNT_W | Sampled processor count |

## Verification
Two pairs of events can fall in the same cycle. The first is a start pulse arriving in the very cycle that done is pulsed and the count is sampled. The bench provokes it by holding `start_i` high across an entire run. The expected result is that the sample stands, the block returns to idle, and no second run begins until start is seen again in idle. The second is the last tolerated busy cycle, which competes with the timeout. The behavioural model in the bench tracks the poll count and is compared with the write strobe, the word, done, error and the count on every clock.

// File: rtl/mp_wake_pkg.sv
package mp_wake_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEND_INIT,
        ST_POLL_INIT,
        ST_WAIT_INIT,
        ST_SEND_SIPI1,
        ST_POLL_SIPI1,
        ST_WAIT_SIPI1,
        ST_SEND_SIPI2,
        ST_POLL_SIPI2,
        ST_WAIT_SIPI2,
        ST_SAMPLE
    } wake_state_e;

    // all-except-self, level assert, initialise mode, vector 0
    localparam logic [31:0] INIT_WORD      = 32'h000C_4500;
    // all-except-self, level assert, start-up mode; vector goes in [7:0]
    localparam logic [23:0] SIPI_WORD_HIGH = 24'h000C_46;

    function automatic int gap_cycles(input longint us, input longint hz);
        return int'((us * hz + 64'd999_999) / 64'd1_000_000);
    endfunction

endpackage

// File: rtl/mp_wake_cmd.sv
module mp_wake_cmd
    import mp_wake_pkg::*;
(
    input  logic        sel_sipi,
    input  logic [7:0]  vec,
    output logic [31:0] word
);
    always_comb begin
        word = sel_sipi ? {SIPI_WORD_HIGH, vec} : INIT_WORD;
    end
endmodule

// File: rtl/mp_wake_delay.sv
module mp_wake_delay #(
    parameter int LONG_T  = 11932,
    parameter int SHORT_T = 239
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic sel_long,
    output logic last
);
    localparam int MAX_T = (LONG_T > SHORT_T) ? LONG_T : SHORT_T;
    localparam int DW    = $clog2(MAX_T + 1);

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] limit;

    always_comb begin
        limit = sel_long ? DW'(LONG_T - 1) : DW'(SHORT_T - 1);
        last  = run && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (run)    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mp_wake_poll.sv
module mp_wake_poll #(
    parameter int BUSY_TMO = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic busy_cycle,
    output logic expired
);
    localparam int PW = $clog2(BUSY_TMO + 1);

    logic [PW-1:0] cnt_q;

    always_comb begin
        expired = busy_cycle && (cnt_q == PW'(BUSY_TMO - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (busy_cycle) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mp_wake_seq.sv
module mp_wake_seq
    import mp_wake_pkg::*;
#(
    parameter int CLK_HZ   = 1193182,
    parameter int INIT_US  = 10000,
    parameter int SIPI_US  = 200,
    parameter int BUSY_TMO = 1024,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             busy_i,
    input  logic [CNT_W-1:0] cpu_count_i,
    input  logic [7:0]       sipi_vec_i,
    output logic             cmd_we_o,
    output logic [31:0]      cmd_data_o,
    output logic             done_o,
    output logic             error_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int INIT_T = gap_cycles(longint'(INIT_US), longint'(CLK_HZ));
    localparam int SIPI_T = gap_cycles(longint'(SIPI_US), longint'(CLK_HZ));

    wake_state_e      state_q, state_d;
    logic [7:0]       vec_q;
    logic [CNT_W-1:0] count_q;
    logic             err_q;

    logic in_send, in_poll, in_wait, sel_sipi, sel_long;
    logic gap_last, poll_expired, accept;

    always_comb begin
        in_send  = (state_q == ST_SEND_INIT) || (state_q == ST_SEND_SIPI1) ||
                   (state_q == ST_SEND_SIPI2);
        in_poll  = (state_q == ST_POLL_INIT) || (state_q == ST_POLL_SIPI1) ||
                   (state_q == ST_POLL_SIPI2);
        in_wait  = (state_q == ST_WAIT_INIT) || (state_q == ST_WAIT_SIPI1) ||
                   (state_q == ST_WAIT_SIPI2);
        sel_sipi = (state_q == ST_SEND_SIPI1) || (state_q == ST_SEND_SIPI2);
        sel_long = (state_q == ST_WAIT_INIT);
        accept   = (state_q == ST_IDLE) && start_i;
    end

    mp_wake_cmd u_cmd (
        .sel_sipi (sel_sipi),
        .vec      (vec_q),
        .word     (cmd_data_o)
    );

    mp_wake_delay #(.LONG_T(INIT_T), .SHORT_T(SIPI_T)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (in_poll),
        .run      (in_wait),
        .sel_long (sel_long),
        .last     (gap_last)
    );

    mp_wake_poll #(.BUSY_TMO(BUSY_TMO)) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (in_send),
        .busy_cycle (in_poll && busy_i),
        .expired    (poll_expired)
    );

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_SEND_INIT;
            ST_SEND_INIT:  state_d = ST_POLL_INIT;
            ST_POLL_INIT:  if (!busy_i) state_d = ST_WAIT_INIT;
                           else if (poll_expired) state_d = ST_IDLE;
            ST_WAIT_INIT:  if (gap_last) state_d = ST_SEND_SIPI1;
            ST_SEND_SIPI1: state_d = ST_POLL_SIPI1;
            ST_POLL_SIPI1: if (!busy_i) state_d = ST_WAIT_SIPI1;
                           else if (poll_expired) state_d = ST_IDLE;
            ST_WAIT_SIPI1: if (gap_last) state_d = ST_SEND_SIPI2;
            ST_SEND_SIPI2: state_d = ST_POLL_SIPI2;
            ST_POLL_SIPI2: if (!busy_i) state_d = ST_WAIT_SIPI2;
                           else if (poll_expired) state_d = ST_IDLE;
            ST_WAIT_SIPI2: if (gap_last) state_d = ST_SAMPLE;
            ST_SAMPLE:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // data held across the run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q   <= '0;
            count_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                vec_q   <= sipi_vec_i;
                count_q <= '0;
                err_q   <= 1'b0;
            end
            if (state_q == ST_SAMPLE)                count_q <= cpu_count_i;
            if (in_poll && busy_i && poll_expired)   err_q   <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cmd_we_o = in_send;
        done_o   = (state_q == ST_SAMPLE);
        count_o  = (state_q == ST_SAMPLE) ? cpu_count_i : count_q;
        error_o  = err_q;
    end
endmodule

// File: rtl/mp_wake_chk.sv
module mp_wake_chk
    import mp_wake_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_i,
    input logic             cmd_we_o,
    input logic [31:0]      cmd_data_o,
    input logic             done_o,
    input logic             error_o,
    input logic [CNT_W-1:0] count_o,
    input wake_state_e      state_q
);
    a_r2_init_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (cmd_we_o && cmd_data_o == 32'h000C4500));

    a_r3_sipi_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_o && state_q != ST_SEND_INIT) |-> (cmd_data_o[31:8] == 24'h000C46));

    a_r4_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_o || (busy_i && (state_q == ST_POLL_INIT || state_q == ST_POLL_SIPI1 ||
                                 state_q == ST_POLL_SIPI2))) |=> !cmd_we_o);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || (state_q == ST_IDLE && !start_i)) |=> $stable(count_o));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> (state_q != ST_SEND_INIT));

    a_r9_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> (state_q == ST_IDLE && !cmd_we_o && !done_o));
endmodule

bind mp_wake_seq mp_wake_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_i     (busy_i),
    .cmd_we_o   (cmd_we_o),
    .cmd_data_o (cmd_data_o),
    .done_o     (done_o),
    .error_o    (error_o),
    .count_o    (count_o),
    .state_q    (state_q)
);

// File: tb/test_mp_wake_seq.sv
`timescale 1ns/1ps
module test_mp_wake_seq;
    localparam int CNT_W = 8;
    localparam int TMO   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             busy_i;
    logic [CNT_W-1:0] cpu_count_i = 8'd1;
    logic [7:0]       sipi_vec_i = 8'h00;
    logic             cmd_we_o, done_o, error_o;
    logic [31:0]      cmd_data_o;
    logic [CNT_W-1:0] count_o;

    always #2.5 clk = ~clk;

    mp_wake_seq #(.CLK_HZ(1193182), .INIT_US(10000), .SIPI_US(200),
                  .BUSY_TMO(TMO), .CNT_W(CNT_W)) i_mp_wake_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
        .cpu_count_i(cpu_count_i), .sipi_vec_i(sipi_vec_i),
        .cmd_we_o(cmd_we_o), .cmd_data_o(cmd_data_o), .done_o(done_o),
        .error_o(error_o), .count_o(count_o));

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int writes = 0;

    // model of the interrupt unit's busy flag
    int busy_len = 0;
    int busy_cnt = 0;
    always @(posedge clk) begin
        if (cmd_we_o)          busy_cnt <= busy_len;
        else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    end
    assign busy_i = (busy_cnt != 0);

    // reference model: 0 idle, 1 send, 2 poll, 3 wait, 4 sample
    int m_mode = 0, m_step = 0, m_pc = 0, m_wc = 0;
    int m_vec = 0, m_held = 0, m_err = 0;
    int lim_long  = int'($ceil(10000.0 * 1193182.0 / 1.0e6));
    int lim_short = int'($ceil(200.0 * 1193182.0 / 1.0e6));
    logic model_on = 1'b0;

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            int e_we, e_done, e_cnt;
            e_we   = (m_mode == 1);
            e_done = (m_mode == 4);
            e_cnt  = (m_mode == 4) ? int'(cpu_count_i) : m_held;
            check("R1 R4 R5 write strobe", cmd_we_o, e_we);
            if (e_we && m_step == 0) check("R2 init word", cmd_data_o, 32'h000C4500);
            if (e_we && m_step != 0) check("R3 start-up word", cmd_data_o, 32'h000C4600 | m_vec);
            check("R6 done", done_o, e_done);
            check("R7 count", count_o, e_cnt);
            check("R9 error", error_o, m_err);
            if (cmd_we_o) writes++;
            case (m_mode)
                0: if (start_i) begin
                       m_mode = 1; m_step = 0; m_vec = sipi_vec_i; m_held = 0; m_err = 0;
                   end
                1: begin m_mode = 2; m_pc = 0; end
                2: if (!busy_i) begin m_mode = 3; m_wc = 0; end
                   else if (m_pc == TMO - 1) begin m_mode = 0; m_err = 1; end
                   else m_pc++;
                3: if (m_wc == ((m_step == 0) ? lim_long : lim_short) - 1) begin
                       if (m_step == 2) m_mode = 4;
                       else begin m_mode = 1; m_step++; end
                   end else m_wc++;
                default: begin m_held = cpu_count_i; m_mode = 0; end
            endcase
        end
    end

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog R1: actual hung expected completion");
            finish_run();
        end
    end

    task automatic pulse_start(input logic [7:0] vec);
        @(posedge clk); #1 start_i = 1'b1; sipi_vec_i = vec;
        @(posedge clk); #1 start_i = 1'b0; sipi_vec_i = ~vec;
    endtask

    task automatic wait_done;
        do @(negedge clk); while (!done_o);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        idle_cycles(3);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset count", count_o, 0);
        check("R9 reset error", error_o, 0);
        check("R6 reset done", done_o, 0);
        model_on = 1'b1;

        // run 1: short busy, vector 0x11, four processors awake
        busy_len = 3; writes = 0;
        pulse_start(8'h11);
        idle_cycles(100);
        cpu_count_i = 8'd4;
        wait_done();
        @(posedge clk); #1 cpu_count_i = 8'd9;
        idle_cycles(20);
        check("R1 three writes per run", writes, 3);
        check("R7 count held after done", count_o, 4);

        // run 2: no busy, start held high throughout (R8, including done cycle)
        busy_len = 0; writes = 0; cpu_count_i = 8'd2;
        @(posedge clk); #1 start_i = 1'b1; sipi_vec_i = 8'hFF;
        @(posedge clk); #1 sipi_vec_i = 8'h00;
        wait_done();
        @(posedge clk); #1 start_i = 1'b0;
        idle_cycles(10);
        check("R8 start ignored while running", writes, 3);
        check("R7 count from run 2", count_o, 2);

        // run 3: busy stays longer than the timeout
        busy_len = 100; writes = 0;
        pulse_start(8'h22);
        idle_cycles(TMO + 20);
        check("R9 abort after init only", writes, 1);
        check("R9 error raised", error_o, 1);
        idle_cycles(120);

        // run 4: busy exactly TMO-1 cycles, error clears on start
        busy_len = TMO - 1; writes = 0; cpu_count_i = 8'd7;
        pulse_start(8'h9A);
        idle_cycles(2);
        check("R9 error cleared by start", error_o, 0);
        wait_done();
        idle_cycles(5);
        check("R4 longest tolerated busy", writes, 3);
        check("R9 no error", error_o, 0);

        finish_run();
    end
endmodule